// File: doc/BRIEF.md
# Card Bus Clock Generator

This block derives the clock that drives a memory card bus from a faster system clock. The division ratio comes from one configuration word carrying two fields: a small integer divider and an optional power-of-two prescaler. A one-cycle command strobe starts the card clock, stops it, or returns the generator to idle at once. A flag tells the host whether the card clock is running.

Software picks the two fields for the frequency it wants. The generator applies a new setting only when an output period ends, so no period is shortened. A stop request waits until the current period ends, so the clock always halts in its low phase. The output is a registered square wave. While the block is idle the output is held low.

Top module: `cardclk_gen`

## Requirements
- R1: After reset, `card_clk_o` and `running_o` are both low and stay low until a start command arrives.
- R2: With the prescale field (`cfg_i[15:4]`) at zero, a divide field d (`cfg_i[3:0]`) from 1 to 15 gives a period of d+1 input cycles. A divide field of 0 is treated as 1, which gives a period of 2 input cycles.
- R3: A nonzero prescale field p multiplies the period by 2·p, so the period is (d+1)·2·p input cycles. This holds for p = 2048.
- R4: Each period begins with a high phase of floor(N/2) input cycles and ends with a low phase of the remaining cycles, where N is the period. An even N therefore gives a 50 % duty cycle.
- R5: A start command (strobe bit 1 set, bit 0 clear) sampled while idle makes `running_o` and `card_clk_o` high on that same clock edge. A stop command sampled while idle has no effect.
- R6: A stop command (strobe bit 0) sampled while running lets the current period finish. At the edge that ends the period, `running_o` and `card_clk_o` both go low. A stop that is sampled in the last cycle of a period takes effect at that edge.
- R7: A configuration change made while running is applied at the next period boundary. The period in progress keeps its old timing.
- R8: A soft-reset command (strobe bit 3) forces the block to idle at the next edge, with the output low and any pending stop cleared. It overrides start and stop sampled in the same cycle.
- R9: When start and stop are sampled together while running, the stop is taken. A start sampled alone while a stop is pending cancels that stop, and the clock keeps running.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Fast input clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_i | input | 16 | Ratio word: [3:0] divide field, [15:4] prescale field |
| strobe_i | input | 4 | One-cycle commands: bit 0 stop, bit 1 start, bit 3 soft reset, bit 2 unused |
| card_clk_o | output | 1 | Divided card bus clock |
| running_o | output | 1 | High while the card clock is running |

## Verification
Two actions can fall on one edge. A stop command can land in the last cycle of a period, and a configuration change can land on the boundary where the next period loads. The bench provokes the first by watching its own model's phase and firing the stop exactly in the final cycle; the clock must then end at that edge rather than one period later. It also gives start and stop together, and soft reset together with start. On every cycle it compares both outputs against a behavioural model, and it measures the high and low lengths of several periods, including the first period after a change made in the middle of a period.

// File: rtl/cardclk_pkg.sv
package cardclk_pkg;
    localparam int DIV_W   = 4;
    localparam int PRE_W   = 12;
    localparam int CFG_W   = DIV_W + PRE_W;
    localparam int RATIO_W = DIV_W + PRE_W + 2;
    localparam int STB_W   = 4;
    localparam int STB_STOP  = 0;
    localparam int STB_START = 1;
    localparam int STB_SRST  = 3;

    typedef struct packed {
        logic run;
        logic pend;
    } ctrl_st_t;

    typedef struct packed {
        logic [RATIO_W-1:0] phase;
        logic [RATIO_W-1:0] ratio;
        logic               clk;
    } phase_st_t;
endpackage

// File: rtl/cardclk_ratio.sv
module cardclk_ratio
    import cardclk_pkg::*;
(
    input  logic [CFG_W-1:0]   cfg_i,
    output logic [RATIO_W-1:0] ratio_o
);
    logic [DIV_W-1:0]   div_f;
    logic [PRE_W-1:0]   pre_f;
    logic [RATIO_W-1:0] stage_n;
    logic [RATIO_W-1:0] scale_n;

    always_comb begin
        div_f   = cfg_i[DIV_W-1:0];
        pre_f   = cfg_i[CFG_W-1:DIV_W];
        // a zero divide field falls back to the fastest legal setting
        stage_n = (div_f == '0) ? RATIO_W'(2) : RATIO_W'(div_f) + RATIO_W'(1);
        scale_n = (pre_f == '0) ? RATIO_W'(1) : (RATIO_W'(pre_f) << 1);
        ratio_o = stage_n * scale_n;
    end
endmodule

// File: rtl/cardclk_ctrl.sv
module cardclk_ctrl
    import cardclk_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic stop_i,
    input  logic start_i,
    input  logic srst_i,
    input  logic boundary_i,
    output logic run_o,
    output logic launch_o,
    output logic idle_o
);
    ctrl_st_t st_d, st_q;
    logic     stop_eff;

    always_comb begin
        st_d     = st_q;
        launch_o = 1'b0;
        idle_o   = 1'b0;
        stop_eff = stop_i | (st_q.pend & ~start_i);
        if (srst_i) begin
            st_d   = '0;
            idle_o = 1'b1;
        end else if (!st_q.run) begin
            if (start_i && !stop_i) begin
                st_d.run = 1'b1;
                launch_o = 1'b1;
            end
        end else if (boundary_i && stop_eff) begin
            // the last cycle of a period is always a low cycle
            st_d   = '0;
            idle_o = 1'b1;
        end else begin
            st_d.pend = stop_eff;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign run_o = st_q.run;
endmodule

// File: rtl/cardclk_phase.sv
module cardclk_phase
    import cardclk_pkg::*;
(
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [RATIO_W-1:0] ratio_i,
    input  logic               run_i,
    input  logic               launch_i,
    input  logic               idle_i,
    output logic               boundary_o,
    output logic               card_clk_o
);
    phase_st_t          st_d, st_q;
    logic [RATIO_W-1:0] phase_inc;

    assign boundary_o = (st_q.phase == st_q.ratio - RATIO_W'(1));
    assign phase_inc  = st_q.phase + RATIO_W'(1);

    always_comb begin
        st_d = st_q;
        if (idle_i || (!run_i && !launch_i)) begin
            st_d.phase = '0;
            st_d.ratio = ratio_i;
            st_d.clk   = 1'b0;
        end else if (launch_i || boundary_o) begin
            st_d.phase = '0;
            st_d.ratio = ratio_i;
            st_d.clk   = 1'b1;
        end else begin
            st_d.phase = phase_inc;
            st_d.clk   = (phase_inc < (st_q.ratio >> 1));
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.phase <= '0;
            st_q.ratio <= RATIO_W'(2);
            st_q.clk   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign card_clk_o = st_q.clk;
endmodule

// File: rtl/cardclk_gen.sv
module cardclk_gen
    import cardclk_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [CFG_W-1:0] cfg_i,
    input  logic [STB_W-1:0] strobe_i,
    output logic             card_clk_o,
    output logic             running_o
);
    logic [RATIO_W-1:0] ratio_w;
    logic               run_w;
    logic               launch_w;
    logic               idle_w;
    logic               boundary_w;
    logic               strobe_unused;

    assign strobe_unused = strobe_i[2];

    cardclk_ratio u_ratio (
        .cfg_i   (cfg_i),
        .ratio_o (ratio_w)
    );

    cardclk_ctrl u_ctrl (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .stop_i     (strobe_i[STB_STOP]),
        .start_i    (strobe_i[STB_START]),
        .srst_i     (strobe_i[STB_SRST]),
        .boundary_i (boundary_w),
        .run_o      (run_w),
        .launch_o   (launch_w),
        .idle_o     (idle_w)
    );

    cardclk_phase u_phase (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .ratio_i    (ratio_w),
        .run_i      (run_w),
        .launch_i   (launch_w),
        .idle_i     (idle_w),
        .boundary_o (boundary_w),
        .card_clk_o (card_clk_o)
    );

    assign running_o = run_w;
endmodule

// File: rtl/cardclk_chk.sv
module cardclk_chk (
    input logic       clk_i,
    input logic       rst_ni,
    input logic [3:0] strobe_i,
    input logic       card_clk_o,
    input logic       running_o
);
    // R1: idle output held low
    a_r1_idle_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !running_o |-> !card_clk_o);

    // R5: a start opens with the high phase
    a_r5_start_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(running_o) |-> card_clk_o);

    // R6: an ordinary stop ends only after a low cycle
    a_r6_stop_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($fell(running_o) && !$past(strobe_i[3])) |-> !$past(card_clk_o));

    // R8: soft reset reaches idle one edge later
    a_r8_srst_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        strobe_i[3] |=> (!running_o && !card_clk_o));

    // R9: a stop taken together with a start never launches from idle
    a_r9_stop_wins_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!running_o && strobe_i[0]) |=> !running_o);
endmodule

bind cardclk_gen cardclk_chk u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .strobe_i   (strobe_i),
    .card_clk_o (card_clk_o),
    .running_o  (running_o)
);

// File: tb/cardclk_gen_tb.sv
module cardclk_gen_tb;
    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic [15:0] cfg_i = 16'h0001;
    logic [3:0]  strobe_i = 4'h0;
    logic        card_clk_o;
    logic        running_o;

    int    n_checks = 0;
    int    n_errors = 0;
    bit    done = 1'b0;
    string cur_req = "R1";

    int m_run = 0, m_pend = 0, m_phase = 0, m_ratio = 2, m_clk = 0;

    always #2.5 clk_i = ~clk_i;

    cardclk_gen u_dut (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .cfg_i      (cfg_i),
        .strobe_i   (strobe_i),
        .card_clk_o (card_clk_o),
        .running_o  (running_o)
    );

    function automatic int ratio_of(logic [15:0] c);
        int d = int'(c[3:0]);
        int p = int'(c[15:4]);
        if (d == 0) d = 1;
        return (d + 1) * ((p == 0) ? 1 : 2 * p);
    endfunction

    // behavioural reference, one step per input clock
    always @(posedge clk_i) begin
        if (!rst_ni) begin
            m_run = 0; m_pend = 0; m_phase = 0; m_clk = 0;
        end else if (strobe_i[3]) begin
            m_run = 0; m_pend = 0; m_phase = 0; m_clk = 0;
        end else if (m_run == 0) begin
            if (strobe_i[1] && !strobe_i[0]) begin
                m_run = 1; m_phase = 0; m_ratio = ratio_of(cfg_i); m_clk = 1;
            end
        end else begin
            int eff;
            bit last;
            eff  = (strobe_i[0] || (m_pend != 0 && !strobe_i[1])) ? 1 : 0;
            last = (m_phase == m_ratio - 1);
            if (last && eff != 0) begin
                m_run = 0; m_pend = 0; m_phase = 0; m_clk = 0;
            end else begin
                m_pend = eff;
                if (last) begin
                    m_phase = 0; m_ratio = ratio_of(cfg_i);
                end else begin
                    m_phase++;
                end
                m_clk = (m_phase < m_ratio / 2) ? 1 : 0;
            end
        end
    end

    task automatic check(int act, int exp, string what);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %0d expected %0d", cur_req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk_i);
        check(int'(card_clk_o), m_clk, "card_clk vs model");
        check(int'(running_o), m_run, "running vs model");
    endtask

    task automatic pulse(logic [3:0] v);
        strobe_i = v;
        tick();
        strobe_i = 4'h0;
    endtask

    task automatic measure(int exp_n);
        int hi = 0, lo = 0, g = 0;
        while (card_clk_o !== 1'b0 && g < 20000) begin tick(); g++; end
        while (card_clk_o !== 1'b1 && g < 20000) begin tick(); g++; end
        while (card_clk_o === 1'b1 && g < 20000) begin hi++; tick(); g++; end
        while (card_clk_o === 1'b0 && g < 20000) begin lo++; tick(); g++; end
        check(hi, exp_n / 2, "high phase length");
        check(hi + lo, exp_n, "period length");
    endtask

    task automatic restart(logic [15:0] c);
        if (m_run != 0) pulse(4'b1000);
        cfg_i = c;
        pulse(4'b0010);
    endtask

    task automatic wait_last();
        int g = 0;
        while (m_phase != m_ratio - 1 && g < 20000) begin tick(); g++; end
    endtask

    initial begin
        repeat (3) @(negedge clk_i);
        rst_ni = 1'b1;
        // R1 reset state
        cur_req = "R1";
        repeat (4) tick();
        check(int'(card_clk_o), 0, "card_clk after reset");
        check(int'(running_o), 0, "running after reset");

        // R5 stop while idle ignored, start launches on next edge
        cur_req = "R5";
        pulse(4'b0001);
        check(int'(running_o), 0, "stop while idle");
        strobe_i = 4'b0010;
        tick();
        strobe_i = 4'h0;
        check(int'(running_o), 1, "running after start");
        check(int'(card_clk_o), 1, "first phase high");

        // R2 divider alone
        cur_req = "R2";
        restart(16'h0001); measure(2);
        restart(16'h0000); measure(2);
        restart(16'h000F); measure(16);
        // R4 odd ratio
        cur_req = "R4";
        restart(16'h0006); measure(7);
        restart(16'h0004); measure(5);

        // R3 prescaler
        cur_req = "R3";
        restart(16'h0011); measure(4);
        restart(16'h0042); measure(24);
        restart(16'h8001); measure(8192);

        // R7 change mid-period
        cur_req = "R7";
        restart(16'h0013); // ratio 8
        measure(8);
        begin
            int g = 0, hi = 0, lo = 0;
            while (m_phase != 1 && g < 100) begin tick(); g++; end
            cfg_i = 16'h0001;
            tick();
            while (card_clk_o === 1'b1 && hi < 100) begin hi++; tick(); end
            while (card_clk_o === 1'b0 && lo < 100) begin lo++; tick(); end
            check(hi + 1, 3, "old high phase kept");
            check(lo, 4, "old low phase kept");
        end
        measure(2);

        // R6 ordinary stop and stop in last cycle
        cur_req = "R6";
        restart(16'h0009); // ratio 10
        repeat (2) tick();
        pulse(4'b0001);
        check(int'(running_o), 1, "still running after stop request");
        repeat (12) tick();
        check(int'(running_o), 0, "stopped at boundary");
        check(int'(card_clk_o), 0, "stopped low");
        restart(16'h0009);
        repeat (3) tick();
        wait_last();
        pulse(4'b0001);
        check(int'(running_o), 0, "stop in last cycle immediate");

        // R9 start with stop, start cancels pending stop
        cur_req = "R9";
        restart(16'h0005);
        tick();
        pulse(4'b0011);
        repeat (8) tick();
        check(int'(running_o), 0, "stop wins over start");
        restart(16'h0005);
        tick();
        pulse(4'b0001);
        pulse(4'b0010);
        repeat (20) tick();
        check(int'(running_o), 1, "start cancels pending stop");

        // R8 soft reset
        cur_req = "R8";
        restart(16'h0007);
        pulse(4'b0001);
        pulse(4'b1010);
        check(int'(running_o), 0, "srst beats start");
        check(int'(card_clk_o), 0, "srst output low");
        pulse(4'b0010);
        repeat (20) tick();
        check(int'(running_o), 1, "pending stop cleared by srst");
        pulse(4'b1000);
        check(int'(running_o), 0, "srst while running");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end
endmodule